// File: doc/BRIEF.md
# Uniform/Affine Register Tag Tracker

This block sits beside the issue stage of a SIMT core. For every vector register of one warp it keeps a two-bit class. The class is one of three:

- **uniform**: every lane holds the same value.
- **affine**: lane t holds base + t·stride.
- **unknown**: nothing is known about the lanes.

Each issued instruction carries an opcode, a destination, two source IDs and a flag that says whether all lanes write. From these the block derives the class of the result, using algebraic rules. On the same cycle it reports the classes of the two sources. It also raises a skip signal when no source the instruction reads is unknown. The datapath uses that signal to gate the vector register file read and the per-lane ALUs, and works on the scalar path instead.

Only two lanes of a uniform or affine vector carry information. For that reason a writeback port delivers the lane-0 and lane-1 result values. The block stores lane 0 as the base of the register and the difference (lane 1 − lane 0) as its stride. It presents base and stride for both sources, so the scalar path can rebuild any lane. Writing the thread index seeds the stored pair directly, without waiting for a writeback.

Top module: `reg_tag_tracker`

## Requirements
- R1: Class codes are 2'b00 unknown, 2'b01 uniform, 2'b10 affine. After reset every register reads unknown, with base 0 and stride 0.
- R2: A full write of opcode 3'd0 (thread index) makes the destination affine and sets its base to 0 and its stride to 1. If a writeback names the same register in the same cycle, the seed wins.
- R3: A full write of opcode 3'd1 (constant broadcast) makes the destination uniform.
- R4: Opcode 3'd2 (add) gives uniform when both sources are uniform. It gives affine when both are known and at least one is affine. It gives unknown when either source is unknown.
- R5: Opcode 3'd3 (multiply) gives uniform for two uniforms and affine for affine with uniform in either order. It gives unknown for two affines or for any unknown source.
- R6: Opcode 3'd4 (load, address in source A) always gives unknown, whatever class the address register has.
- R7: Opcodes 3'd5 to 3'd7 have no rule and give unknown.
- R8: A partial write (iss_full low) leaves the destination unknown, whatever the opcode and the source classes.
- R9: A writeback stores lane 0 as the base and (lane 1 − lane 0) modulo 2^DW as the stride of the named register. It leaves every class untouched.
- R10: The source class outputs show the class of the named registers after all writes up to the previous clock edge. The instruction on the same cycle has no effect on them.
- R11: vrf_skip is high only while iss_valid is high and no source the opcode reads is unknown. Thread index and constant read no source, load reads only source A, and every other opcode reads both. Class updates happen only when iss_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_op | input | 3 | Opcode |
| iss_dst | input | IDW | Destination register |
| iss_src_a | input | IDW | Source A register |
| iss_src_b | input | IDW | Source B register |
| iss_full | input | 1 | All lanes of the destination are written |
| wb_valid | input | 1 | Result lane values are delivered |
| wb_reg | input | IDW | Register the result belongs to |
| wb_lane0 | input | DW | Lane-0 value of the result |
| wb_lane1 | input | DW | Lane-1 value of the result |
| src_a_tag | output | 2 | Class of source A |
| src_b_tag | output | 2 | Class of source B |
| src_a_base | output | DW | Stored base of source A |
| src_a_stride | output | DW | Stored stride of source A |
| src_b_base | output | DW | Stored base of source B |
| src_b_stride | output | DW | Stored stride of source B |
| vrf_skip | output | 1 | Gate the vector register file read and lane ALUs |

## Verification
The assertions take for granted that every input is at a known level once reset is released. They also assume that the issue and writeback ports may name the same register in the same cycle; the seed from a thread-index write then overrides the writeback. The stimulus changes inputs only at the falling edge and never leaves them undriven. It covers all eight opcodes with partial writes mixed in, and it makes writeback and issue collide on one register so that this ordering is exercised.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        TAG_K = 2'b00,
        TAG_U = 2'b01,
        TAG_A = 2'b10
    } tag_t;

    localparam logic [2:0] OP_TID   = 3'd0;
    localparam logic [2:0] OP_CONST = 3'd1;
    localparam logic [2:0] OP_ADD   = 3'd2;
    localparam logic [2:0] OP_MUL   = 3'd3;
    localparam logic [2:0] OP_LOAD  = 3'd4;

endpackage

// File: rtl/tt_rule.sv
module tt_rule
    import tt_pkg::*;
(
    input  logic [2:0] op,
    input  logic       full,
    input  tag_t       tag_a,
    input  tag_t       tag_b,
    output tag_t       res_tag,
    output logic       use_a,
    output logic       use_b
);

    logic any_k;
    logic both_u;
    logic both_a;

    always_comb begin
        any_k   = (tag_a == TAG_K) || (tag_b == TAG_K);
        both_u  = (tag_a == TAG_U) && (tag_b == TAG_U);
        both_a  = (tag_a == TAG_A) && (tag_b == TAG_A);
        use_a   = 1'b1;
        use_b   = 1'b1;
        res_tag = TAG_K;
        case (op)
            OP_TID: begin
                use_a   = 1'b0;
                use_b   = 1'b0;
                res_tag = TAG_A;
            end
            OP_CONST: begin
                use_a   = 1'b0;
                use_b   = 1'b0;
                res_tag = TAG_U;
            end
            OP_ADD: begin
                if (any_k)       res_tag = TAG_K;
                else if (both_u) res_tag = TAG_U;
                else             res_tag = TAG_A;
            end
            OP_MUL: begin
                if (any_k || both_a) res_tag = TAG_K;
                else if (both_u)     res_tag = TAG_U;
                else                 res_tag = TAG_A;
            end
            OP_LOAD: begin
                use_b   = 1'b0;
                res_tag = TAG_K;
            end
            default: res_tag = TAG_K;
        endcase
        if (!full) begin
            res_tag = TAG_K;
        end
    end

endmodule

// File: rtl/tt_tag_file.sv
module tt_tag_file
    import tt_pkg::*;
#(
    parameter int NREG = 16,
    parameter int IDW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [IDW-1:0] wr_idx,
    input  tag_t           wr_tag,
    input  logic [IDW-1:0] rd_a_idx,
    input  logic [IDW-1:0] rd_b_idx,
    output tag_t           rd_a_tag,
    output tag_t           rd_b_tag
);

    typedef struct packed {
        tag_t [NREG-1:0] tag;
    } tag_state_t;

    tag_state_t st_d;
    tag_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.tag[wr_idx] = wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_tag = st_q.tag[rd_a_idx];
    assign rd_b_tag = st_q.tag[rd_b_idx];

    AST_TAG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.tag[$past(wr_idx)] == $past(wr_tag)); // R10

endmodule

// File: rtl/tt_affine_file.sv
module tt_affine_file #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int IDW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wb_en,
    input  logic [IDW-1:0] wb_idx,
    input  logic [DW-1:0]  wb_lane0,
    input  logic [DW-1:0]  wb_lane1,
    input  logic           seed_en,
    input  logic [IDW-1:0] seed_idx,
    input  logic [IDW-1:0] rd_a_idx,
    input  logic [IDW-1:0] rd_b_idx,
    output logic [DW-1:0]  rd_a_base,
    output logic [DW-1:0]  rd_a_stride,
    output logic [DW-1:0]  rd_b_base,
    output logic [DW-1:0]  rd_b_stride
);

    localparam logic [DW-1:0] UNIT_STRIDE = DW'(1);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] base;
        logic [NREG-1:0][DW-1:0] stride;
    } aff_state_t;

    aff_state_t st_d;
    aff_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (wb_en) begin
            st_d.base[wb_idx]   = wb_lane0;
            st_d.stride[wb_idx] = wb_lane1 - wb_lane0;
        end
        if (seed_en) begin
            st_d.base[seed_idx]   = '0;
            st_d.stride[seed_idx] = UNIT_STRIDE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_base   = st_q.base[rd_a_idx];
    assign rd_a_stride = st_q.stride[rd_a_idx];
    assign rd_b_base   = st_q.base[rd_b_idx];
    assign rd_b_stride = st_q.stride[rd_b_idx];

    AST_TID_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        seed_en |=> (st_q.base[$past(seed_idx)] == '0)
                 && (st_q.stride[$past(seed_idx)] == UNIT_STRIDE)); // R2

    AST_WB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !(seed_en && seed_idx == wb_idx))
        |=> (st_q.base[$past(wb_idx)] == $past(wb_lane0))
         && (st_q.stride[$past(wb_idx)] == $past(wb_lane1 - wb_lane0))); // R9

endmodule

// File: rtl/reg_tag_tracker.sv
module reg_tag_tracker
    import tt_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int IDW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           iss_valid,
    input  logic [2:0]     iss_op,
    input  logic [IDW-1:0] iss_dst,
    input  logic [IDW-1:0] iss_src_a,
    input  logic [IDW-1:0] iss_src_b,
    input  logic           iss_full,
    input  logic           wb_valid,
    input  logic [IDW-1:0] wb_reg,
    input  logic [DW-1:0]  wb_lane0,
    input  logic [DW-1:0]  wb_lane1,
    output logic [1:0]     src_a_tag,
    output logic [1:0]     src_b_tag,
    output logic [DW-1:0]  src_a_base,
    output logic [DW-1:0]  src_a_stride,
    output logic [DW-1:0]  src_b_base,
    output logic [DW-1:0]  src_b_stride,
    output logic           vrf_skip
);

    tag_t tag_a;
    tag_t tag_b;
    tag_t rule_tag;
    logic use_a;
    logic use_b;
    logic seed_en;

    tt_tag_file #(.NREG(NREG), .IDW(IDW)) i_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (iss_valid),
        .wr_idx   (iss_dst),
        .wr_tag   (rule_tag),
        .rd_a_idx (iss_src_a),
        .rd_b_idx (iss_src_b),
        .rd_a_tag (tag_a),
        .rd_b_tag (tag_b)
    );

    tt_rule i_rule (
        .op      (iss_op),
        .full    (iss_full),
        .tag_a   (tag_a),
        .tag_b   (tag_b),
        .res_tag (rule_tag),
        .use_a   (use_a),
        .use_b   (use_b)
    );

    assign seed_en = iss_valid && (iss_op == OP_TID) && iss_full;

    tt_affine_file #(.NREG(NREG), .DW(DW), .IDW(IDW)) i_aff (
        .clk         (clk),
        .rst_n       (rst_n),
        .wb_en       (wb_valid),
        .wb_idx      (wb_reg),
        .wb_lane0    (wb_lane0),
        .wb_lane1    (wb_lane1),
        .seed_en     (seed_en),
        .seed_idx    (iss_dst),
        .rd_a_idx    (iss_src_a),
        .rd_b_idx    (iss_src_b),
        .rd_a_base   (src_a_base),
        .rd_a_stride (src_a_stride),
        .rd_b_base   (src_b_base),
        .rd_b_stride (src_b_stride)
    );

    always_comb begin
        vrf_skip = iss_valid
                && (!use_a || tag_a != TAG_K)
                && (!use_b || tag_b != TAG_K);
    end

    assign src_a_tag = tag_a;
    assign src_b_tag = tag_b;

    AST_IDLE_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> !vrf_skip); // R11

    AST_SKIP_ADD_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (vrf_skip && iss_op == OP_ADD)
        |-> (src_a_tag != 2'b00) && (src_b_tag != 2'b00)); // R11

    AST_ADD_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_full && iss_op == OP_ADD && src_a_tag == 2'b01 && src_b_tag == 2'b01)
        |-> rule_tag == TAG_U); // R4

    AST_MUL_AFFINE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_op == OP_MUL && src_a_tag == 2'b10 && src_b_tag == 2'b10)
        |-> rule_tag == TAG_K); // R5

    AST_LOAD_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        iss_op == OP_LOAD |-> rule_tag == TAG_K); // R6

    AST_PARTIAL_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_full |-> rule_tag == TAG_K); // R8

endmodule

// File: tb/test_reg_tag_tracker.sv
module test_reg_tag_tracker;

    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int IDW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           iss_valid = 1'b0;
    logic [2:0]     iss_op = '0;
    logic [IDW-1:0] iss_dst = '0;
    logic [IDW-1:0] iss_src_a = '0;
    logic [IDW-1:0] iss_src_b = '0;
    logic           iss_full = 1'b0;
    logic           wb_valid = 1'b0;
    logic [IDW-1:0] wb_reg = '0;
    logic [DW-1:0]  wb_lane0 = '0;
    logic [DW-1:0]  wb_lane1 = '0;
    logic [1:0]     src_a_tag;
    logic [1:0]     src_b_tag;
    logic [DW-1:0]  src_a_base;
    logic [DW-1:0]  src_a_stride;
    logic [DW-1:0]  src_b_base;
    logic [DW-1:0]  src_b_stride;
    logic           vrf_skip;

    int errors = 0;
    int checks = 0;
    int mt[NREG];
    logic [DW-1:0] mb[NREG];
    logic [DW-1:0] ms[NREG];

    always #4 clk = ~clk;

    reg_tag_tracker #(.NREG(NREG), .DW(DW), .IDW(IDW)) i_reg_tag_tracker (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_full(iss_full), .wb_valid(wb_valid), .wb_reg(wb_reg),
        .wb_lane0(wb_lane0), .wb_lane1(wb_lane1), .src_a_tag(src_a_tag),
        .src_b_tag(src_b_tag), .src_a_base(src_a_base),
        .src_a_stride(src_a_stride), .src_b_base(src_b_base),
        .src_b_stride(src_b_stride), .vrf_skip(vrf_skip)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Class of a result, from the requirement text (0 unknown, 1 uniform, 2 affine)
    function automatic int ref_tag(int op, int ta, int tb, bit full);
        if (!full) return 0;                                   // R8
        if (op == 0) return 2;                                 // R2
        if (op == 1) return 1;                                 // R3
        if (op == 2) begin                                     // R4
            if (ta == 0 || tb == 0) return 0;
            return (ta == 1 && tb == 1) ? 1 : 2;
        end
        if (op == 3) begin                                     // R5
            if (ta == 0 || tb == 0) return 0;
            if (ta == 2 && tb == 2) return 0;
            return (ta == 1 && tb == 1) ? 1 : 2;
        end
        return 0;                                              // R6, R7
    endfunction

    function automatic bit ref_skip(bit v, int op, int ta, int tb);
        if (!v) return 1'b0;
        if (op == 0 || op == 1) return 1'b1;
        if (op == 4) return ta != 0;
        return (ta != 0) && (tb != 0);
    endfunction

    task automatic step(bit v, int op, int dst, int sa, int sb, bit full,
                        bit wv, int wr, logic [DW-1:0] l0, logic [DW-1:0] l1);
        int nt;
        @(negedge clk);
        iss_valid = v; iss_op = op[2:0]; iss_dst = dst[IDW-1:0];
        iss_src_a = sa[IDW-1:0]; iss_src_b = sb[IDW-1:0]; iss_full = full;
        wb_valid = wv; wb_reg = wr[IDW-1:0]; wb_lane0 = l0; wb_lane1 = l1;
        #1;
        chk("R10 src_a_tag", 32'(src_a_tag), 32'(mt[sa]));
        chk("R10 src_b_tag", 32'(src_b_tag), 32'(mt[sb]));
        chk("R11 vrf_skip", 32'(vrf_skip), 32'(ref_skip(v, op, mt[sa], mt[sb])));
        chk("R9 src_a_base", src_a_base, mb[sa]);
        chk("R9 src_a_stride", src_a_stride, ms[sa]);
        chk("R9 src_b_base", src_b_base, mb[sb]);
        chk("R9 src_b_stride", src_b_stride, ms[sb]);
        nt = ref_tag(op, mt[sa], mt[sb], full);
        @(posedge clk);
        if (v) mt[dst] = nt;
        if (wv) begin
            mb[wr] = l0;
            ms[wr] = l1 - l0;
        end
        if (v && op == 0 && full) begin
            mb[dst] = '0;
            ms[dst] = 1;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            mt[i] = 0; mb[i] = '0; ms[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: every register unknown with zero base and stride after reset
        for (int r = 0; r < NREG; r++) begin
            @(negedge clk);
            iss_valid = 1'b0; iss_src_a = r[IDW-1:0]; iss_src_b = r[IDW-1:0];
            #1;
            chk("R1 reset tag", 32'(src_a_tag), 32'd0);
            chk("R1 reset base", src_a_base, 32'd0);
            chk("R1 reset stride", src_a_stride, 32'd0);
        end
        step(1, 0, 1, 0, 0, 1, 0, 0, 0, 0);            // R2 thread index into r1
        step(1, 1, 2, 1, 1, 1, 1, 2, 32'd7, 32'd7);    // R3 constant into r2, lanes 7/7
        step(1, 2, 3, 1, 2, 1, 0, 0, 0, 0);            // R4 affine+uniform
        step(1, 2, 4, 2, 2, 1, 0, 0, 0, 0);            // R4 uniform+uniform
        step(1, 3, 5, 2, 1, 1, 0, 0, 0, 0);            // R5 uniform*affine
        step(1, 3, 6, 1, 1, 1, 0, 0, 0, 0);            // R5 affine*affine
        step(1, 3, 7, 6, 2, 1, 0, 0, 0, 0);            // R5 unknown*uniform
        step(1, 4, 8, 1, 0, 1, 0, 0, 0, 0);            // R6 load via affine address
        step(1, 5, 9, 2, 2, 1, 0, 0, 0, 0);            // R7 undefined opcode
        step(1, 1, 10, 2, 2, 0, 0, 0, 0, 0);           // R8 partial constant write
        step(0, 1, 11, 3, 4, 1, 0, 0, 0, 0);           // R11 idle: no update, no skip
        step(1, 0, 1, 5, 6, 1, 1, 1, 32'd50, 32'd9);   // R2 seed beats same-cycle writeback
        step(1, 2, 12, 3, 4, 1, 1, 2, 32'd20, 32'd5);  // R9 stride wraps below zero
        step(1, 4, 13, 8, 2, 1, 0, 0, 0, 0);           // R11 load with unknown address
        step(0, 0, 0, 2, 11, 0, 0, 0, 0, 0);           // R10 readback of r2 and r11
        step(0, 0, 0, 10, 1, 0, 0, 0, 0, 0);           // R8/R2 readback of r10 and r1
        for (int n = 0; n < 1500; n++) begin
            step($urandom_range(0, 4) != 0, $urandom_range(0, 7),
                 $urandom_range(0, NREG - 1), $urandom_range(0, NREG - 1),
                 $urandom_range(0, NREG - 1), $urandom_range(0, 5) != 0,
                 $urandom_range(0, 1) != 0, $urandom_range(0, NREG - 1),
                 $urandom, $urandom);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule